// File: doc/BRIEF.md
# Programmable bus-cycle waveform generator

This block turns one 32-bit microcode word into the waveforms that a chip-select line and general-purpose line 0 follow during a single external bus clock cycle. It runs on a fast internal clock. A selectable divide ratio of 2, 4 or 8 sets how many fast clocks make up one bus cycle. At ratio 4 and 8 the bus cycle is cut into four quarter phases. At ratio 2 it is cut into two half phases.

A sequencer offers a word by raising `word_valid`. The word and the divide ratio are captured together, and the cycle starts on the next clock. Four bits at the top of the word give the chip-select level for each phase. A two-bit field gives the level of general-purpose line 0 during the first half of the cycle. `cycle_done` marks the final fast clock of the cycle, and a new word offered in that same clock follows with no gap. The reserved code of the line field keeps the line at its last level and raises a sticky fault flag. Between cycles, chip-select rests high and general-purpose line 0 follows the default mode bit.

Top module: `buswave_gen`

## Requirements
- R1: After reset and while idle: `busy`=0, `cycle_done`=0, `fault`=0, `cs_line`=1, and `gp0_line` equals `gp0_default`.
- R2: `ratio_sel` is captured at acceptance: 0 selects ratio 2 (a 2-clock cycle), 1 selects ratio 4 (a 4-clock cycle), 2 or 3 selects ratio 8 (an 8-clock cycle). `busy` is high from the clock after acceptance for exactly that many clocks. `cycle_done` is high only in the last of them.
- R3: At ratio 4 or 8, the four quarter phases are of equal length. `cs_line` equals word bit 31, 30, 29 and 28 in quarter phases 1, 2, 3 and 4.
- R4: At ratio 2, `cs_line` equals word bit 31 in the first clock and word bit 29 in the second. Word bits 30 and 28 have no effect.
- R5: During the first half of the cycle (quarter phases 1 and 2, or the first half phase at ratio 2), the field at word bits 23:22 drives `gp0_line`: 2'b10 drives 0, 2'b11 drives 1, and 2'b00 drives `gp0_default`. During the second half, `gp0_line` equals `gp0_default`.
- R6: Field code 2'b01 keeps `gp0_line` at its value from the previous clock and sets `fault` from the next clock on. `fault` stays set until reset.
- R7: A word is accepted only when idle or in a clock with `cycle_done` high; in the latter case the next cycle follows with no idle clock. `word_valid` at any other time, and any change of `word_in` or `ratio_sel` during a cycle, has no effect on the outputs.
- R8: Word bits 27:24 and 21:0 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ratio_sel | input | 2 | Divide ratio select, captured at acceptance |
| word_valid | input | 1 | Offers `word_in` for the next bus cycle |
| word_in | input | 32 | Microcode word |
| gp0_default | input | 1 | Default level for general-purpose line 0 |
| cs_line | output | 1 | Chip-select waveform, 1 when idle |
| gp0_line | output | 1 | General-purpose line 0 waveform |
| busy | output | 1 | A bus cycle is in progress |
| cycle_done | output | 1 | Final fast clock of the current cycle |
| fault | output | 1 | Sticky flag set by the reserved line code |

## Verification
The hardest cases to reach are the word boundaries. One is a back-to-back start, where `word_valid` has to land exactly in the `cycle_done` clock. The other is the reserved line code right after such a start, where the held value comes from the second half of the previous cycle and not from the idle default. The stimulus keeps `word_valid` high across whole cycles so that every offer outside the final clock must be dropped. It chains words of different ratios through their final clocks and puts the reserved code into a chained word. It also changes `word_in` and `ratio_sel` to their complements during each cycle, so that late capture shows at the ports.

// File: rtl/buswave_gen.sv
module buswave_gen #(
  parameter logic CS_IDLE = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  ratio_sel,
  input  logic        word_valid,
  input  logic [31:0] word_in,
  input  logic        gp0_default,
  output logic        cs_line,
  output logic        gp0_line,
  output logic        busy,
  output logic        cycle_done,
  output logic        fault
);

  localparam logic [1:0] M_HALF = 2'd0;
  localparam logic [1:0] M_QTR  = 2'd1;
  localparam logic [1:0] M_SLOW = 2'd2;

  logic       busy_q, sub_q, gp_prev, fault_q;
  logic [1:0] ph_q, mode_q, gf_q;
  logic [3:0] cs_q;

  wire unused_bits = ^{word_in[27:24], word_in[21:0]};

  wire half_mode  = (mode_q == M_HALF);
  wire step       = (mode_q != M_SLOW) | sub_q;
  wire last_ph    = half_mode ? ph_q[0] : (ph_q == 2'd3);
  wire done       = busy_q & step & last_ph;
  wire accept     = word_valid & (~busy_q | done);
  wire first_half = half_mode ? (ph_q == 2'd0) : ~ph_q[1];

  logic cs_pick, gp_pick;

  always_comb begin
    if (half_mode)
      cs_pick = ph_q[0] ? cs_q[1] : cs_q[3];
    else
      case (ph_q)
        2'd0:    cs_pick = cs_q[3];
        2'd1:    cs_pick = cs_q[2];
        2'd2:    cs_pick = cs_q[1];
        default: cs_pick = cs_q[0];
      endcase
  end

  always_comb begin
    if (!busy_q || !first_half)
      gp_pick = gp0_default;
    else
      case (gf_q)
        2'b00:   gp_pick = gp0_default;
        2'b01:   gp_pick = gp_prev;
        2'b10:   gp_pick = 1'b0;
        default: gp_pick = 1'b1;
      endcase
  end

  assign cs_line    = busy_q ? cs_pick : CS_IDLE;
  assign gp0_line   = gp_pick;
  assign busy       = busy_q;
  assign cycle_done = done;
  assign fault      = fault_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      ph_q    <= 2'd0;
      sub_q   <= 1'b0;
      mode_q  <= M_HALF;
      cs_q    <= 4'd0;
      gf_q    <= 2'd0;
      gp_prev <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      gp_prev <= gp_pick;
      if (busy_q && first_half && gf_q == 2'b01)
        fault_q <= 1'b1;
      if (accept) begin
        busy_q <= 1'b1;
        ph_q   <= 2'd0;
        sub_q  <= 1'b0;
        cs_q   <= word_in[31:28];
        gf_q   <= word_in[23:22];
        case (ratio_sel)
          2'd0:    mode_q <= M_HALF;
          2'd1:    mode_q <= M_QTR;
          default: mode_q <= M_SLOW;
        endcase
      end else if (busy_q) begin
        if (mode_q == M_SLOW)
          sub_q <= ~sub_q;
        if (done)
          busy_q <= 1'b0;
        else if (step)
          ph_q <= ph_q + 2'd1;
      end
    end
  end

endmodule

// File: rtl/buswave_gen_chk.sv
module buswave_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       word_valid,
  input logic       gp0_default,
  input logic       cs_line,
  input logic       gp0_line,
  input logic       busy,
  input logic       cycle_done,
  input logic       fault,
  input logic       first_half,
  input logic [1:0] gf_q,
  input logic [3:0] cs_q
);

  a_r1_idle_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_line);

  a_r2_done_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done |-> busy);

  a_r2_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done && !word_valid |=> !busy);

  a_r5_second_half: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !first_half |-> gp0_line == gp0_default);

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy && first_half && gf_q == 2'b01 |-> gp0_line == $past(gp0_line));

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);

  a_r7_word_stable: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !cycle_done |=> $stable(cs_q) && $stable(gf_q));

endmodule

bind buswave_gen buswave_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .gp0_default(gp0_default),
  .cs_line(cs_line), .gp0_line(gp0_line), .busy(busy), .cycle_done(cycle_done),
  .fault(fault), .first_half(first_half), .gf_q(gf_q), .cs_q(cs_q)
);

// File: tb/test_buswave_gen.sv
module test_buswave_gen;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] ratio_sel = 2'd0;
  logic word_valid = 1'b0, gp0_default = 1'b0;
  logic [31:0] word_in = '0;
  logic cs_line, gp0_line, busy, cycle_done, fault;

  buswave_gen i_buswave_gen (.*);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  string tag = "R1";

  // behavioural reference
  bit m_busy = 0, m_fault = 0, m_prevgp = 0;
  int m_t = 0, m_len = 2;
  bit [31:0] m_word = '0;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog %s: got hang, expected finish", tag);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(string what, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    bit e_cs, e_gp, e_done, first;
    int q;
    #1;
    e_cs = 1; e_gp = gp0_default; e_done = 0; first = 0;
    if (m_busy) begin
      if (m_len == 2) begin
        e_cs = (m_t == 0) ? m_word[31] : m_word[29];
        first = (m_t == 0);
      end else begin
        q = m_t / (m_len / 4);
        e_cs = m_word[31 - q];
        first = (q < 2);
      end
      if (first)
        case (m_word[23:22])
          2'b10: e_gp = 0;
          2'b11: e_gp = 1;
          2'b01: e_gp = m_prevgp;
          default: e_gp = gp0_default;
        endcase
      e_done = (m_t == m_len - 1);
    end
    chk("cs_line", cs_line, e_cs);
    chk("gp0_line", gp0_line, e_gp);
    chk("busy", busy, m_busy);
    chk("cycle_done", cycle_done, e_done);
    chk("fault", fault, m_fault);
    if (m_busy && first && m_word[23:22] == 2'b01) m_fault = 1;
    m_prevgp = e_gp;
    if (m_busy && !e_done) m_t++;
    else if (word_valid) begin
      m_busy = 1; m_t = 0; m_word = word_in;
      m_len = (ratio_sel == 0) ? 2 : (ratio_sel == 1) ? 4 : 8;
    end else m_busy = 0;
    @(negedge clk);
  endtask

  // offer a word, scramble inputs while busy, optionally hold valid
  task automatic run(bit [1:0] rs, bit [31:0] w, bit hold, int idle);
    ratio_sel = rs; word_in = w; word_valid = 1;
    tick();
    word_valid = hold;
    word_in = ~w; ratio_sel = ~rs;
    while (m_busy && !(m_t == m_len - 1)) tick();
    word_valid = 0;
    tick();
    for (int i = 0; i < idle; i++) tick();
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    tag = "R1";
    tick(); gp0_default = 1; tick(); tick();
    rst_n = 1;
    tick(); gp0_default = 0; tick();

    tag = "R2 R3 ratio4";
    run(2'd1, 32'hA000_0000 | (2'b10 << 22), 0, 1);
    run(2'd1, 32'h5000_0000 | (2'b11 << 22), 0, 1);
    tag = "R2 R3 ratio8";
    run(2'd2, 32'hC000_0000 | (2'b11 << 22), 0, 1);
    run(2'd3, 32'h3000_0000 | (2'b10 << 22), 0, 2);
    tag = "R2 R4 ratio2 ignores bits 30,28";
    run(2'd0, 32'h5000_0000, 0, 1);
    run(2'd0, 32'hA000_0000 | (2'b11 << 22), 0, 1);
    run(2'd0, 32'h2000_0000 | (2'b10 << 22), 0, 1);

    tag = "R5 default field";
    gp0_default = 1; run(2'd1, 32'h9000_0000, 0, 1);
    gp0_default = 0; run(2'd2, 32'h6000_0000 | (2'b11 << 22), 0, 1);
    gp0_default = 1; run(2'd1, 32'h0000_0000 | (2'b10 << 22), 0, 1);

    tag = "R8 reserved bits";
    run(2'd1, 32'hA000_0000 | 32'h0F3F_FFFF & ~(32'h3 << 22) | (2'b10 << 22), 0, 1);
    run(2'd0, 32'h0F3F_FFFF | (2'b11 << 22), 0, 1);

    tag = "R7 back-to-back and ignored valid";
    gp0_default = 0;
    ratio_sel = 1; word_in = 32'hB000_0000 | (2'b11 << 22); word_valid = 1;
    tick(); tick(); tick();
    word_in = 32'h4000_0000 | (2'b10 << 22); ratio_sel = 0;
    tick(); tick();
    word_in = 32'hE000_0000; ratio_sel = 2;
    tick(); tick(); tick(); tick(); tick(); tick(); tick();
    word_in = 32'h1000_0000 | (2'b11 << 22); ratio_sel = 1;
    tick(); word_valid = 0;
    for (int i = 0; i < 6; i++) tick();

    tag = "R6 reserved holds, fault sticky";
    gp0_default = 1;
    run(2'd1, 32'h5000_0000 | (2'b01 << 22), 0, 2);
    gp0_default = 0;
    run(2'd2, 32'h9000_0000 | (2'b01 << 22), 0, 1);
    ratio_sel = 1; word_in = 32'h0000_0000 | (2'b10 << 22); word_valid = 1;
    tick(); word_valid = 1; tick(); tick(); tick();
    word_in = 32'h8000_0000 | (2'b01 << 22); ratio_sel = 0;
    tick(); word_valid = 0;
    for (int i = 0; i < 4; i++) tick();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule